// File: doc/BRIEF.md
# Delayed Pixel Word Output with Per-Pixel Blanking

This block drives the 10-bit parallel pixel output of an image digitizer. Each converted word is held back by a fixed number of data-clock cycles so that the output bus lines up with the converter's pipeline latency. While a word is held back, it carries a one-bit blank mark with it.

The blank mark is set when the preblank strobe is high and both clamp strobes are low. Either clamp strobe, optical-black or dummy-pixel, overrides preblanking for that pixel. A marked word leaves the block as all zeros. An unmarked word leaves unchanged. If the preblank strobe is tied low, the block is a plain delay.

All inputs are captured on the rising edge of the data clock. The output is registered on that same edge.

Top module: `pix_out_pipe`

## Requirements
- R1: A word applied before rising edge t appears on `pix_out` just after edge t+8, which is LATENCY = 9 register stages. The next word replaces it just after edge t+9.
- R2: A word captured with `blank_req` = 1, `clamp_black` = 0 and `clamp_dummy` = 0 leaves as 10'h000.
- R3: A word captured with `clamp_black` = 1 is not blanked, whatever the state of `blank_req`.
- R4: A word captured with `clamp_dummy` = 1 is not blanked, whatever the state of `blank_req`.
- R5: A word captured with `blank_req` = 0 leaves unchanged. Output bit i equals input bit i, with bit 9 as the MSB and bit 0 as the LSB.
- R6: `rst` is active-high and synchronous. An edge with `rst` = 1 clears every stage, and `pix_out` reads 10'h000 right after that edge.
- R7: After the last reset edge, `pix_out` stays 10'h000 for the next 8 edges, whatever the inputs. The first word captured after reset is the first word to appear.
- R8: The blanking decision is made per pixel. A blanked word between two unblanked words leaves both neighbours intact, each on its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all capture and output on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 10 | Converted pixel word |
| blank_req | input | 1 | Preblank strobe for the current pixel |
| clamp_black | input | 1 | Optical-black clamp strobe; overrides preblank |
| clamp_dummy | input | 1 | Dummy-pixel clamp strobe; overrides preblank |
| pix_out | output | 10 | Delayed, possibly zeroed, pixel word |

## Verification
The bench builds the block with its defaults: WIDTH = 10 and LATENCY = 9. With these values, the first eight table rows land inside the post-reset flush window, so the first outputs must read zero even though the inputs are non-zero. Every later row crosses the full nine-stage depth. The table covers all eight combinations of the preblank strobe and the two clamp strobes, with data patterns that expose swapped or dropped bits. Directed runs then check a reset taken in mid-stream and an isolated blanked pixel between two live ones.

// File: rtl/pix_pkg.sv
package pix_pkg;
  localparam int unsigned PIX_W_DEFAULT = 10;
  localparam int unsigned PIX_LAT_DEFAULT = 9;

  // Blank only when preblank is asked for and no clamp strobe claims the pixel.
  function automatic logic pix_blank_mark(input logic req, input logic ob, input logic dm);
    return req & ~ob & ~dm;
  endfunction
endpackage

// File: rtl/pix_capture.sv
module pix_capture #(
  parameter int unsigned WIDTH = pix_pkg::PIX_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] smp,
  input  logic             blank_req,
  input  logic             clamp_black,
  input  logic             clamp_dummy,
  output logic [WIDTH-1:0] cap_data,
  output logic             cap_blank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data  <= '0;
      cap_blank <= 1'b0;
    end else begin
      cap_data  <= smp;
      cap_blank <= pix_pkg::pix_blank_mark(blank_req, clamp_black, clamp_dummy);
    end
  end

  p_ob_override_r3: assert property (@(posedge clk) disable iff (rst)
    clamp_black |=> !cap_blank);
  p_dm_override_r4: assert property (@(posedge clk) disable iff (rst)
    clamp_dummy |=> !cap_blank);
  p_no_req_r5: assert property (@(posedge clk) disable iff (rst)
    !blank_req |=> !cap_blank);
endmodule

// File: rtl/pix_delay.sv
module pix_delay #(
  parameter int unsigned WIDTH  = pix_pkg::PIX_W_DEFAULT,
  parameter int unsigned STAGES = pix_pkg::PIX_LAT_DEFAULT - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_blank,
  output logic [WIDTH-1:0] out_data,
  output logic             out_blank
);
  if (STAGES == 0) begin : g_none
    assign out_data  = in_data;
    assign out_blank = in_blank;
  end else begin : g_line
    logic [WIDTH-1:0] d_q [STAGES];
    logic             b_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_st
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) begin
            d_q[s] <= '0;
            b_q[s] <= 1'b0;
          end else begin
            d_q[s] <= in_data;
            b_q[s] <= in_blank;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) begin
            d_q[s] <= '0;
            b_q[s] <= 1'b0;
          end else begin
            d_q[s] <= d_q[s-1];
            b_q[s] <= b_q[s-1];
          end
        end
      end
    end

    assign out_data  = d_q[STAGES-1];
    assign out_blank = b_q[STAGES-1];
  end
endmodule

// File: rtl/pix_out_reg.sv
module pix_out_reg #(
  parameter int unsigned WIDTH = pix_pkg::PIX_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_blank,
  output logic [WIDTH-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)           dout <= '0;
    else if (in_blank) dout <= '0;
    else               dout <= in_data;
  end

  p_blank_zero_r2: assert property (@(posedge clk) disable iff (rst)
    in_blank |=> (dout == '0));
  p_pass_r5: assert property (@(posedge clk) disable iff (rst)
    !in_blank |=> (dout == $past(in_data)));
endmodule

// File: rtl/pix_out_pipe.sv
module pix_out_pipe #(
  parameter int unsigned WIDTH   = pix_pkg::PIX_W_DEFAULT,
  parameter int unsigned LATENCY = pix_pkg::PIX_LAT_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pix_in,
  input  logic             blank_req,
  input  logic             clamp_black,
  input  logic             clamp_dummy,
  output logic [WIDTH-1:0] pix_out
);
  localparam int unsigned MID = LATENCY - 2;
  localparam int unsigned CW  = $clog2(LATENCY + 1);

  logic [WIDTH-1:0] c_data, m_data;
  logic             c_blank, m_blank;

  pix_capture #(.WIDTH(WIDTH)) u_cap (
    .clk(clk), .rst(rst), .smp(pix_in), .blank_req(blank_req),
    .clamp_black(clamp_black), .clamp_dummy(clamp_dummy),
    .cap_data(c_data), .cap_blank(c_blank));

  pix_delay #(.WIDTH(WIDTH), .STAGES(MID)) u_dly (
    .clk(clk), .rst(rst), .in_data(c_data), .in_blank(c_blank),
    .out_data(m_data), .out_blank(m_blank));

  pix_out_reg #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .in_data(m_data), .in_blank(m_blank),
    .dout(pix_out));

  // Edges since reset, saturating; drives only the flush check below.
  logic [CW-1:0] fill_q;
  always_ff @(posedge clk) begin
    if (rst)                        fill_q <= '0;
    else if (fill_q != CW'(LATENCY)) fill_q <= fill_q + 1'b1;
  end

  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_q < CW'(LATENCY)) |-> (pix_out == '0));
endmodule

// File: tb/sim_pix_out_pipe.sv
`timescale 1ns/1ps
module sim_pix_out_pipe;
  localparam int W = 10;
  localparam int LAT = 9;
  localparam int NV = 20;
  // {blank_req, clamp_black, clamp_dummy, data}
  localparam logic [12:0] VEC [NV] = '{
    {3'b000, 10'h3FF}, {3'b000, 10'h001}, {3'b000, 10'h200}, {3'b100, 10'h155},
    {3'b100, 10'h2AA}, {3'b110, 10'h123}, {3'b101, 10'h0F0}, {3'b111, 10'h30C},
    {3'b010, 10'h045}, {3'b001, 10'h3C3}, {3'b000, 10'h1A5}, {3'b100, 10'h3FF},
    {3'b000, 10'h2DB}, {3'b100, 10'h001}, {3'b100, 10'h200}, {3'b011, 10'h111},
    {3'b000, 10'h000}, {3'b110, 10'h3FE}, {3'b000, 10'h17F}, {3'b100, 10'h3FF}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pix_in = '0;
  logic blank_req = 1'b0, clamp_black = 1'b0, clamp_dummy = 1'b0;
  logic [W-1:0] pix_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pix_out_pipe u0 (.clk(clk), .rst(rst), .pix_in(pix_in), .blank_req(blank_req),
    .clamp_black(clamp_black), .clamp_dummy(clamp_dummy), .pix_out(pix_out));

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pix_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [12:0] v);
    {blank_req, clamp_black, clamp_dummy, pix_in} = v;
  endtask

  function automatic logic [W-1:0] expect_word(input logic [12:0] v);
    return (v[12] && !v[11] && !v[10]) ? '0 : v[W-1:0];
  endfunction

  function automatic string req_of(input logic [12:0] v);
    if (v[12] && !v[11] && !v[10]) return "R2/R1";
    if (v[12] && v[11])            return "R3/R1";
    if (v[12] && v[10])            return "R4/R1";
    return "R5/R1";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pix_out, '0, "R6 reset state");

    // Table walk; edge k captures VEC[k], output after edge k holds VEC[k-8].
    rst = 1'b0;
    for (int k = 0; k < NV + LAT - 1; k++) begin
      drive(k < NV ? VEC[k] : 13'h0);
      @(posedge clk);
      @(negedge clk);
      if (k < LAT - 1) check(pix_out, '0, "R7 flush");
      else check(pix_out, expect_word(VEC[k-(LAT-1)]), req_of(VEC[k-(LAT-1)]));
    end

    // R8: isolated blanked pixel between two live ones.
    drive({3'b000, 10'h2F0}); @(posedge clk); @(negedge clk);
    drive({3'b100, 10'h0FF}); @(posedge clk); @(negedge clk);
    drive({3'b000, 10'h301}); @(posedge clk); @(negedge clk);
    drive(13'h0);
    repeat (6) @(posedge clk);
    @(negedge clk); check(pix_out, 10'h2F0, "R8 leading neighbour");
    @(posedge clk); @(negedge clk); check(pix_out, 10'h000, "R8 blanked pixel");
    @(posedge clk); @(negedge clk); check(pix_out, 10'h301, "R8 trailing neighbour");

    // Reset in mid-stream, then flush and first word (R6, R7, R1).
    drive({3'b000, 10'h155});
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk); check(pix_out, 10'h155, "R5 steady stream");
    rst = 1'b1;
    @(posedge clk); @(negedge clk); check(pix_out, '0, "R6 mid-stream reset");
    rst = 1'b0;
    drive({3'b000, 10'h2AA});
    for (int k = 0; k < LAT - 1; k++) begin
      @(posedge clk); @(negedge clk);
      check(pix_out, '0, "R7 post-reset flush");
    end
    @(posedge clk); @(negedge clk);
    check(pix_out, 10'h2AA, "R1 first word after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule